// File: doc/BRIEF.md
# Converter Result Offset and Range Post-Processor

This block takes the signed, extended result of a successive-approximation converter and corrects it before it reaches the output register. A host programs a small two's-complement offset through a chip-select and write strobe on a shared 15-bit data bus. At every end of conversion the block adds the stored offset to the raw result and forms the final 15-bit output word.

A clip-enable input selects one of two output formats. With clipping on, the sum is held to the nominal 14-bit code range. Bit 14 then tells the host that the raw input itself was outside the nominal span. With clipping off, the whole extended sum is passed on all 15 bits. Offset writes that are malformed or out of range are refused and flagged. A write that arrives during a conversion is held back until that conversion has used the old offset.

Top module: `ocp_post_proc`

## Requirements
- R1: After reset the stored offset is zero, and both result_vld_o and wr_err_o are low.
- R2: A falling edge of wr_i, seen at a clock edge while cs_ni is low, stores bus_i[11:0] as a two's-complement offset if the write is valid. A falling edge of wr_i while cs_ni is high has no effect and raises no error.
- R3: A write whose bus_i[14:12] is not zero is refused and the stored offset is kept. wr_err_o goes high for exactly one cycle, in the cycle after the edge on which the falling edge of wr_i was seen.
- R4: A write whose 12-bit value lies outside -1310..+1310 is refused in the same way as in R3. The values -1310 and +1310 themselves are accepted.
- R5: Every cycle with eoc_i high is followed, one cycle later, by exactly one cycle of result_vld_o with the corrected word on result_o.
- R6: With clip_en_i high, result_o[13:0] is raw_i + offset held to the range 0..16383.
- R7: With clip_en_i high, result_o[14] is 1 exactly when raw_i < 0 or raw_i > 16383, whatever the offset.
- R8: With clip_en_i low, result_o is raw_i + offset modulo 2^15, so negative sums appear as 15-bit two's complement (raw 0 with offset -512 gives 0x7E00; raw 16383 with offset +1024 gives 17407).
- R9: A valid write seen while conv_busy_i is high and eoc_i is low is deferred. The conversion that ends next still uses the old offset, and the new offset applies to the conversions after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select for offset writes, active low |
| wr_i | input | 1 | Write strobe; its falling edge latches the bus |
| bus_i | input | 15 | Offset write word: bits 14:12 zero, bits 11:0 the offset |
| conv_busy_i | input | 1 | High while a conversion is in progress |
| eoc_i | input | 1 | One-cycle end-of-conversion pulse; raw_i is valid in that cycle |
| raw_i | input | 16 | Signed extended raw converter result |
| clip_en_i | input | 1 | Selects clamped output with an overrange flag |
| result_o | output | 15 | Corrected output word |
| result_vld_o | output | 1 | result_o is valid |
| wr_err_o | output | 1 | One-cycle pulse for a refused offset write |

## Verification
Raw values are chosen inside the nominal span, below zero and above full scale. Each is run with zero, positive and negative offsets, in both clip settings. This separates an output clamped on the sum from one flagged on the raw value, and a wrapped negative sum from a clamped one. Offset writes cover the exact limits and one code beyond each, nonzero top bits, and a strobe with chip select high. Each write is followed by a conversion that shows which offset is in force. One write is issued during a busy conversion to show the old offset is used for that conversion and the new one for the conversion after it.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int unsigned BusW  = 15;
  localparam int unsigned CodeW = 14;
  localparam int unsigned OffW  = 12;
  localparam int unsigned RawW  = 16;
  localparam int          OffLim = 1310;

  typedef enum logic [1:0] {
    RNG_IN = 2'd0,
    RNG_LO = 2'd1,
    RNG_HI = 2'd2
  } rng_e;
endpackage

// File: rtl/ocp_wr_port.sv
module ocp_wr_port #(
  parameter int unsigned BUS_W   = ocp_pkg::BusW,
  parameter int unsigned OFF_W   = ocp_pkg::OffW,
  parameter int          OFF_LIM = ocp_pkg::OffLim
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    wr_i,
  input  logic [BUS_W-1:0]        bus_i,
  output logic                    acc_o,
  output logic signed [OFF_W-1:0] acc_val_o,
  output logic                    rej_o
);
  logic wr_q;
  logic fall;
  logic top_ok;
  logic rng_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  assign fall      = wr_q & ~wr_i & ~cs_ni;
  assign acc_val_o = $signed(bus_i[OFF_W-1:0]);
  assign top_ok    = (bus_i[BUS_W-1:OFF_W] == '0);
  assign rng_ok    = (acc_val_o >= -OFF_LIM) && (acc_val_o <= OFF_LIM);
  assign acc_o     = fall & top_ok & rng_ok;
  assign rej_o     = fall & ~(top_ok & rng_ok);
endmodule

// File: rtl/ocp_off_reg.sv
module ocp_off_reg #(
  parameter int unsigned OFF_W = ocp_pkg::OffW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    acc_i,
  input  logic signed [OFF_W-1:0] acc_val_i,
  input  logic                    busy_i,
  input  logic                    eoc_i,
  output logic signed [OFF_W-1:0] off_o
);
  logic                    pend_q;
  logic signed [OFF_W-1:0] pend_val_q;
  logic                    commit_ok;

  // eoc edge: the adder still sees off_o, the new value lands for the next one
  assign commit_ok = ~busy_i | eoc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_o      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
    end else if (acc_i) begin
      if (commit_ok) begin
        off_o  <= acc_val_i;
        pend_q <= 1'b0;
      end else begin
        pend_val_q <= acc_val_i;
        pend_q     <= 1'b1;
      end
    end else if (pend_q && commit_ok) begin
      off_o  <= pend_val_q;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ocp_result_calc.sv
module ocp_result_calc #(
  parameter int unsigned RAW_W  = ocp_pkg::RawW,
  parameter int unsigned OFF_W  = ocp_pkg::OffW,
  parameter int unsigned CODE_W = ocp_pkg::CodeW,
  parameter int unsigned BUS_W  = ocp_pkg::BusW
) (
  input  logic signed [RAW_W-1:0] raw_i,
  input  logic signed [OFF_W-1:0] off_i,
  input  logic                    clip_en_i,
  output logic [BUS_W-1:0]        word_o
);
  import ocp_pkg::*;

  localparam int unsigned SUM_W  = RAW_W + 1;
  localparam int          CODE_MAX = (1 << CODE_W) - 1;
  localparam int unsigned PAD_W  = BUS_W - CODE_W - 1;

  logic signed [SUM_W-1:0] sum;
  logic                    raw_out;
  rng_e                    sum_rng;
  logic [CODE_W-1:0]       clamped;
  logic [BUS_W-1:0]        clip_word;

  assign sum     = SUM_W'(raw_i) + SUM_W'(off_i);
  assign raw_out = (raw_i < 0) || (raw_i > CODE_MAX);

  always_comb begin
    if (sum < 0)             sum_rng = RNG_LO;
    else if (sum > CODE_MAX) sum_rng = RNG_HI;
    else                     sum_rng = RNG_IN;
  end

  always_comb begin
    unique case (sum_rng)
      RNG_LO:  clamped = '0;
      RNG_HI:  clamped = '1;
      default: clamped = sum[CODE_W-1:0];
    endcase
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign clip_word = {{PAD_W{1'b0}}, raw_out, clamped};
    end else begin : g_nopad
      assign clip_word = {raw_out, clamped};
    end
  endgenerate

  assign word_o = clip_en_i ? clip_word : sum[BUS_W-1:0];
endmodule

// File: rtl/ocp_post_proc.sv
module ocp_post_proc #(
  parameter int unsigned BUS_W   = ocp_pkg::BusW,
  parameter int unsigned CODE_W  = ocp_pkg::CodeW,
  parameter int unsigned OFF_W   = ocp_pkg::OffW,
  parameter int unsigned RAW_W   = ocp_pkg::RawW,
  parameter int          OFF_LIM = ocp_pkg::OffLim
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cs_ni,
  input  logic                    wr_i,
  input  logic [BUS_W-1:0]        bus_i,
  input  logic                    conv_busy_i,
  input  logic                    eoc_i,
  input  logic signed [RAW_W-1:0] raw_i,
  input  logic                    clip_en_i,
  output logic [BUS_W-1:0]        result_o,
  output logic                    result_vld_o,
  output logic                    wr_err_o
);
  logic                    acc;
  logic                    rej;
  logic signed [OFF_W-1:0] acc_val;
  logic signed [OFF_W-1:0] off;
  logic [BUS_W-1:0]        word;

  ocp_wr_port #(.BUS_W(BUS_W), .OFF_W(OFF_W), .OFF_LIM(OFF_LIM)) u_wr (
    .clk_i, .rst_ni, .cs_ni, .wr_i, .bus_i,
    .acc_o(acc), .acc_val_o(acc_val), .rej_o(rej)
  );

  ocp_off_reg #(.OFF_W(OFF_W)) u_off (
    .clk_i, .rst_ni, .acc_i(acc), .acc_val_i(acc_val),
    .busy_i(conv_busy_i), .eoc_i, .off_o(off)
  );

  ocp_result_calc #(.RAW_W(RAW_W), .OFF_W(OFF_W), .CODE_W(CODE_W), .BUS_W(BUS_W)) u_calc (
    .raw_i, .off_i(off), .clip_en_i, .word_o(word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o     <= '0;
      result_vld_o <= 1'b0;
      wr_err_o     <= 1'b0;
    end else begin
      result_vld_o <= eoc_i;
      wr_err_o     <= rej;
      if (eoc_i) result_o <= word;
    end
  end
endmodule

// File: rtl/ocp_post_proc_chk.sv
module ocp_post_proc_chk #(
  parameter int unsigned BUS_W   = ocp_pkg::BusW,
  parameter int unsigned CODE_W  = ocp_pkg::CodeW,
  parameter int unsigned OFF_W   = ocp_pkg::OffW,
  parameter int unsigned RAW_W   = ocp_pkg::RawW,
  parameter int          OFF_LIM = ocp_pkg::OffLim
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_ni,
  input logic                    wr_i,
  input logic [BUS_W-1:0]        bus_i,
  input logic                    eoc_i,
  input logic signed [RAW_W-1:0] raw_i,
  input logic                    clip_en_i,
  input logic [BUS_W-1:0]        result_o,
  input logic                    result_vld_o,
  input logic                    wr_err_o
);
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic seen_q;
  logic wr_d;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      wr_d   <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      wr_d   <= wr_i;
    end
  end

  assign fall = wr_d & ~wr_i & ~cs_ni;

  AST_VLD_AFTER_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && eoc_i |=> result_vld_o); // R5
  AST_VLD_NEEDS_EOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && result_vld_o |-> $past(eoc_i)); // R5
  AST_OVR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && eoc_i && clip_en_i |=>
      result_o[CODE_W] == (($past(raw_i) < 0) || ($past(raw_i) > CODE_MAX))); // R7
  AST_CLIP_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && eoc_i && clip_en_i && (raw_i > CODE_MAX + OFF_LIM) |=>
      result_o[CODE_W-1:0] == '1); // R6
  AST_CLIP_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && eoc_i && clip_en_i && (raw_i < -OFF_LIM) |=>
      result_o[CODE_W-1:0] == '0); // R6
  AST_BAD_TOP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && fall && (bus_i[BUS_W-1:OFF_W] != '0) |=> wr_err_o); // R3
  AST_ERR_NEEDS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && wr_err_o |-> $past(fall)); // R2
endmodule

bind ocp_post_proc ocp_post_proc_chk #(
  .BUS_W(BUS_W), .CODE_W(CODE_W), .OFF_W(OFF_W), .RAW_W(RAW_W), .OFF_LIM(OFF_LIM)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .wr_i(wr_i), .bus_i(bus_i),
  .eoc_i(eoc_i), .raw_i(raw_i), .clip_en_i(clip_en_i), .result_o(result_o),
  .result_vld_o(result_vld_o), .wr_err_o(wr_err_o)
);

// File: tb/ocp_post_proc_tb.sv
module ocp_post_proc_tb;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               cs_ni = 1'b1;
  logic               wr_i = 1'b0;
  logic [14:0]        bus_i = '0;
  logic               conv_busy_i = 1'b0;
  logic               eoc_i = 1'b0;
  logic signed [15:0] raw_i = '0;
  logic               clip_en_i = 1'b0;
  logic [14:0]        result_o;
  logic               result_vld_o;
  logic               wr_err_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [14:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ocp_post_proc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni, .wr_i, .bus_i, .conv_busy_i,
    .eoc_i, .raw_i, .clip_en_i, .result_o, .result_vld_o, .wr_err_o
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [14:0] exp_word(int raw, int off, bit clip);
    int s;
    logic [31:0] sv;
    logic ovr;
    s = raw + off;
    if (clip) begin
      ovr = (raw < 0) || (raw > 16383);
      if (s < 0) s = 0;
      if (s > 16383) s = 16383;
      sv = s;
      return {ovr, sv[13:0]};
    end
    sv = s;
    return sv[14:0];
  endfunction

  // driver: one conversion, expectation queued for the monitor
  task automatic convert(int raw, int off, bit clip, string tag);
    @(negedge clk);
    raw_i = 16'(raw);
    clip_en_i = clip;
    eoc_i = 1'b1;
    exp_q.push_back(exp_word(raw, off, clip));
    tag_q.push_back(tag);
    @(negedge clk);
    eoc_i = 1'b0;
  endtask

  task automatic wr_off(logic [14:0] v, bit sel, bit exp_err, string tag);
    @(negedge clk);
    cs_ni = ~sel;
    bus_i = v;
    wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
    @(negedge clk);
    chk(wr_err_o == exp_err, tag, int'(wr_err_o), int'(exp_err));
    cs_ni = 1'b1;
    @(negedge clk);
    chk(wr_err_o == 1'b0, {tag, " err pulse one cycle"}, int'(wr_err_o), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && result_vld_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected result_vld_o", 1, 0);
      end else begin
        logic [14:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(result_o == e, t, int'(result_o), int'(e));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result_vld_o == 1'b0, "R1 vld in reset", int'(result_vld_o), 0);
    chk(wr_err_o == 1'b0, "R1 err in reset", int'(wr_err_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result_vld_o == 1'b0, "R1 vld after reset", int'(result_vld_o), 0);

    convert(5000, 0, 1'b1, "R1 zero offset after reset");
    convert(17000, 0, 1'b1, "R6 R7 clip high raw");
    convert(-300, 0, 1'b1, "R6 R7 clip low raw");
    convert(-300, 0, 1'b0, "R8 negative raw wraps");

    wr_off(15'd1024, 1'b1, 1'b0, "R2 write +1024");
    convert(16383, 1024, 1'b1, "R6 sum clamp, R7 raw in range");
    convert(16383, 1024, 1'b0, "R8 full scale +1024");
    convert(0, 1024, 1'b0, "R8 zero +1024");

    wr_off(15'h0E00, 1'b1, 1'b0, "R2 write -512");
    convert(0, -512, 1'b0, "R8 zero -512");
    convert(0, -512, 1'b1, "R6 clip sum below zero");
    convert(16895, -512, 1'b1, "R7 raw over range flagged");

    wr_off(15'h1005, 1'b1, 1'b1, "R3 top bits nonzero");
    convert(0, -512, 1'b0, "R3 offset kept");
    wr_off(15'h051F, 1'b1, 1'b1, "R4 +1311 rejected");
    wr_off(15'h0AE1, 1'b1, 1'b1, "R4 -1311 rejected");
    convert(100, -512, 1'b0, "R4 offset kept");
    wr_off(15'h051E, 1'b1, 1'b0, "R4 +1310 accepted");
    convert(100, 1310, 1'b0, "R4 +1310 applied");
    wr_off(15'h0AE2, 1'b1, 1'b0, "R4 -1310 accepted");
    convert(2000, -1310, 1'b1, "R4 -1310 applied");

    wr_off(15'd300, 1'b0, 1'b0, "R2 cs high no error");
    convert(2000, -1310, 1'b1, "R2 cs high ignored");

    @(negedge clk);
    conv_busy_i = 1'b1;
    wr_off(15'd200, 1'b1, 1'b0, "R9 write during busy");
    convert(1000, -1310, 1'b0, "R9 old offset at end of busy conversion");
    conv_busy_i = 1'b0;
    convert(1000, 200, 1'b0, "R9 new offset next conversion");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule